// File: doc/BRIEF.md
# PC Card Memory Access Decoder

This block sits between a 16-bit PC Card style host bus and a bank of byte-wide SRAM devices plus a small attribute memory. Each clock it samples the two active-low card enables, A0, the upper address bits, output enable, write enable and the attribute select. From these it works out the access mode: standby, byte, word or odd-byte-only. It then issues per-bank low-byte and high-byte chip selects, a shared read strobe and a shared write strobe, an attribute chip select, and the steering that places each device byte on the correct host data lane.

The host data bus is split into an input, an output and a per-lane output enable. A lane's enable is raised only while a valid read is in progress, so the block never drives the host while the host is writing. All device-side controls and the lane enables are registered. Their effect appears one clock after the host inputs are sampled. Read data is muxed straight from the device read buses, using that registered steering.

Top module: `sramcard_decoder`

## Requirements
- R1: With both card enables high (standby), one cycle later every common chip select and the attribute chip select are high, both strobes are high and both lane enables are 0, whatever output enable and write enable show.
- R2: With the low enable active and the high enable inactive (byte access), A0=0 selects the low-byte device and A0=1 selects the high-byte device. Either way the byte travels on host bits 7:0 only: lane enable = 2'b01, and write data for the high-byte device is taken from host bits 7:0.
- R3: With both enables active (word access), both byte devices of the bank are selected, whatever A0 is. The even byte is on host bits 7:0, the odd byte is on bits 15:8, and the lane enable on a read is 2'b11.
- R4: With the high enable active and the low enable inactive (odd-byte-only access), only the high-byte device is selected. Data uses host bits 15:8, and the lane enable on a read is 2'b10.
- R5: A read is output enable low with write enable high, and it drives the strobe mem_rd_n low. A write is write enable low with output enable high, and it drives mem_wr_n low. With neither active, no chip select, strobe or lane enable is asserted. Lane enables are nonzero only during a valid read.
- R6: Output enable and write enable both low is an invalid cycle. No chip select or strobe is asserted, both lanes stay disabled, and memory contents are unchanged.
- R7: With the attribute select low, common chip selects stay high. Only the even byte is reachable, through attr_cs_n. Odd attribute bytes read as 8'h00 on their enabled lane, and writes to odd attribute bytes store nothing.
- R8: The host address splits at a fixed point. Bits DEV_AW-1:0 go to dev_addr. Bits ADDR_W-1:DEV_AW pick the bank index b, and only dev_cs_lo_n[b] and dev_cs_hi_n[b] may go low.
- R9: While wp_switch is 1, a write to common memory still selects its devices but mem_wr_n stays high, so nothing is stored. Reads of common memory and writes to attribute memory are unaffected.
- R10: host_wait_n is always 1, and host_wp always equals wp_switch.
- R11: A synchronous active-low reset puts every chip select and strobe high and both lane enables to 0. Outside reset, every registered output reflects the host inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_ce_lo_n | input | 1 | Low (even) byte card enable, active low |
| host_ce_hi_n | input | 1 | High (odd) byte card enable, active low |
| host_a0 | input | 1 | Byte address bit 0 |
| host_addr | input | ADDR_W | Host address bits above A0 |
| host_oe_n | input | 1 | Output enable, active low |
| host_we_n | input | 1 | Write enable, active low |
| host_attr_n | input | 1 | Attribute space select, active low |
| wp_switch | input | 1 | Write protect switch, 1 = protected |
| host_d_in | input | 16 | Write data from host |
| host_d_out | output | 16 | Read data to host |
| host_d_oe | output | 2 | Per-lane drive enable (bit0 = bits 7:0, bit1 = bits 15:8) |
| host_wait_n | output | 1 | Wait indication, constant inactive |
| host_wp | output | 1 | Write protect status |
| dev_addr | output | DEV_AW | Address to every byte device |
| dev_cs_lo_n | output | NBANK | Low-byte device selects, active low |
| dev_cs_hi_n | output | NBANK | High-byte device selects, active low |
| mem_rd_n | output | 1 | Shared read strobe, active low |
| mem_wr_n | output | 1 | Shared write strobe, active low |
| dev_wd_lo | output | 8 | Write data for low-byte devices and attribute memory |
| dev_wd_hi | output | 8 | Write data for high-byte devices |
| dev_rd_lo | input | 8 | Shared read bus of low-byte devices |
| dev_rd_hi | input | 8 | Shared read bus of high-byte devices |
| attr_addr | output | ATT_AW | Attribute memory address |
| attr_cs_n | output | 1 | Attribute memory select, active low |
| attr_rd | input | 8 | Attribute memory read data |

## Verification
Chip selects, strobes, lane enables and write data are due one rising edge after the host inputs are presented. Read data is due in the same cycle as the lane enables, because the bench's device models answer combinationally. A write lands in the device model on the edge after its strobe is registered. So a read placed in the very next host cycle already sees the new value. The driver presents each access at a falling edge and queues its expectation tagged with the following cycle number. The monitor samples at the next falling edge, which keeps every comparison half a clock away from any edge that changes the outputs.

// File: rtl/sramcard_pkg.sv
// Shared types for the PC Card memory access decoder.
package sramcard_pkg;

    // Source of the byte placed on host data bits 7:0
    typedef enum logic [1:0] {
        SRC_LO_DEV = 2'd0,
        SRC_HI_DEV = 2'd1,
        SRC_ATTR   = 2'd2,
        SRC_ZERO   = 2'd3
    } lane_src_e;

    // Result of classifying one host cycle
    typedef struct packed {
        logic       rd;        // valid read
        logic       wr;        // valid write
        logic       use_lo;    // even byte device takes part
        logic       use_hi;    // odd byte device takes part
        logic [1:0] lanes;     // host lanes carrying data
        logic       byte_odd;  // 8-bit access to the odd byte via lane 0
    } acc_dec_t;

endpackage

// File: rtl/cycle_decode.sv
// cycle_decode: classifies the host control pins into an access.
// Assumes: pins are already synchronous to clk; purely combinational.
module cycle_decode
    import sramcard_pkg::*;
(
    input  logic     ce_lo_n,
    input  logic     ce_hi_n,
    input  logic     a0,
    input  logic     oe_n,
    input  logic     we_n,
    output acc_dec_t dec
);
    logic byte_m;
    logic word_m;
    logic odd_m;
    logic any_en;

    // Mode split from the two card enables and the strobe qualification
    always_comb begin
        byte_m = !ce_lo_n && ce_hi_n;
        word_m = !ce_lo_n && !ce_hi_n;
        odd_m  = ce_lo_n && !ce_hi_n;
        any_en = byte_m || word_m || odd_m;

        dec.rd       = any_en && !oe_n && we_n;
        dec.wr       = any_en && oe_n && !we_n;
        dec.use_lo   = word_m || (byte_m && !a0);
        dec.use_hi   = word_m || odd_m || (byte_m && a0);
        dec.lanes    = {!ce_hi_n, !ce_lo_n};
        dec.byte_odd = byte_m && a0;
    end
endmodule

// File: rtl/bank_select.sv
// bank_select: one-of-N decode of the bank index into split byte selects.
// Assumes: en_lo/en_hi already include cycle validity; outputs active low.
module bank_select #(
    parameter int BANK_W = 2,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic              en_lo,
    input  logic              en_hi,
    input  logic [BANK_W-1:0] bank,
    output logic [NBANK-1:0]  cs_lo_n,
    output logic [NBANK-1:0]  cs_hi_n
);
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        // Select for bank g, one byte half each
        always_comb begin
            cs_lo_n[g] = !(en_lo && (bank == BANK_W'(g)));
            cs_hi_n[g] = !(en_hi && (bank == BANK_W'(g)));
        end
    end
endmodule

// File: rtl/lane_router.sv
// lane_router: places device read bytes onto the host data lanes.
// Assumes: select inputs are registered; read buses answer in-cycle.
module lane_router
    import sramcard_pkg::*;
(
    input  lane_src_e   lo_src,
    input  logic        hi_from_dev,
    input  logic [7:0]  rd_lo,
    input  logic [7:0]  rd_hi,
    input  logic [7:0]  rd_attr,
    output logic [15:0] dout
);
    // Low lane mux and high lane gate
    always_comb begin
        unique case (lo_src)
            SRC_LO_DEV: dout[7:0] = rd_lo;
            SRC_HI_DEV: dout[7:0] = rd_hi;
            SRC_ATTR:   dout[7:0] = rd_attr;
            default:    dout[7:0] = 8'h00;
        endcase
        dout[15:8] = hi_from_dev ? rd_hi : 8'h00;
    end
endmodule

// File: rtl/sramcard_decoder.sv
// sramcard_decoder: PC Card host bus to byte-wide SRAM bank decoder.
// Registers all device controls one cycle after sampling the host pins;
// read data is steered combinationally from the device read buses.
// Assumes: host pins synchronous to clk; attribute memory is byte wide on
// the even lane only; write protect guards common memory only.
module sramcard_decoder
    import sramcard_pkg::*;
#(
    parameter int DEV_AW = 4,
    parameter int BANK_W = 2,
    parameter int ATT_AW = 3,
    localparam int ADDR_W = DEV_AW + BANK_W,
    localparam int NBANK  = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ce_lo_n,
    input  logic              host_ce_hi_n,
    input  logic              host_a0,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_oe_n,
    input  logic              host_we_n,
    input  logic              host_attr_n,
    input  logic              wp_switch,
    input  logic [15:0]       host_d_in,
    output logic [15:0]       host_d_out,
    output logic [1:0]        host_d_oe,
    output logic              host_wait_n,
    output logic              host_wp,
    output logic [DEV_AW-1:0] dev_addr,
    output logic [NBANK-1:0]  dev_cs_lo_n,
    output logic [NBANK-1:0]  dev_cs_hi_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [7:0]        dev_wd_lo,
    output logic [7:0]        dev_wd_hi,
    input  logic [7:0]        dev_rd_lo,
    input  logic [7:0]        dev_rd_hi,
    output logic [ATT_AW-1:0] attr_addr,
    output logic              attr_cs_n,
    input  logic [7:0]        attr_rd
);
    acc_dec_t          dec;
    logic              acc_any;
    logic              common_en;
    logic [NBANK-1:0]  cs_lo_n_d;
    logic [NBANK-1:0]  cs_hi_n_d;
    logic              attr_cs_n_d;
    logic              rd_n_d;
    logic              wr_n_d;
    logic [1:0]        oe_d;
    lane_src_e         lo_src_d;
    lane_src_e         lo_src_q;
    logic              hi_dev_q;
    logic [7:0]        wd_hi_d;

    cycle_decode u_decode (
        .ce_lo_n (host_ce_lo_n),
        .ce_hi_n (host_ce_hi_n),
        .a0      (host_a0),
        .oe_n    (host_oe_n),
        .we_n    (host_we_n),
        .dec     (dec)
    );

    // Qualify the access by space and protection
    always_comb begin
        acc_any     = dec.rd || dec.wr;
        common_en   = acc_any && host_attr_n;
        attr_cs_n_d = !(acc_any && !host_attr_n && dec.use_lo);
        rd_n_d      = !dec.rd;
        wr_n_d      = !(dec.wr && !(host_attr_n && wp_switch));
        oe_d        = dec.rd ? dec.lanes : 2'b00;
        wd_hi_d     = dec.byte_odd ? host_d_in[7:0] : host_d_in[15:8];
        if (host_attr_n)
            lo_src_d = dec.byte_odd ? SRC_HI_DEV : SRC_LO_DEV;
        else
            lo_src_d = dec.use_lo ? SRC_ATTR : SRC_ZERO;
    end

    bank_select #(.BANK_W(BANK_W)) u_bank (
        .en_lo   (common_en && dec.use_lo),
        .en_hi   (common_en && dec.use_hi),
        .bank    (host_addr[ADDR_W-1:DEV_AW]),
        .cs_lo_n (cs_lo_n_d),
        .cs_hi_n (cs_hi_n_d)
    );

    // Register device controls and steering
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_cs_lo_n <= '1;
            dev_cs_hi_n <= '1;
            attr_cs_n   <= 1'b1;
            mem_rd_n    <= 1'b1;
            mem_wr_n    <= 1'b1;
            host_d_oe   <= 2'b00;
            lo_src_q    <= SRC_ZERO;
            hi_dev_q    <= 1'b0;
            dev_addr    <= '0;
            attr_addr   <= '0;
            dev_wd_lo   <= '0;
            dev_wd_hi   <= '0;
        end else begin
            dev_cs_lo_n <= cs_lo_n_d;
            dev_cs_hi_n <= cs_hi_n_d;
            attr_cs_n   <= attr_cs_n_d;
            mem_rd_n    <= rd_n_d;
            mem_wr_n    <= wr_n_d;
            host_d_oe   <= oe_d;
            lo_src_q    <= lo_src_d;
            hi_dev_q    <= host_attr_n;
            dev_addr    <= host_addr[DEV_AW-1:0];
            attr_addr   <= host_addr[ATT_AW-1:0];
            dev_wd_lo   <= host_d_in[7:0];
            dev_wd_hi   <= wd_hi_d;
        end
    end

    lane_router u_router (
        .lo_src      (lo_src_q),
        .hi_from_dev (hi_dev_q),
        .rd_lo       (dev_rd_lo),
        .rd_hi       (dev_rd_hi),
        .rd_attr     (attr_rd),
        .dout        (host_d_out)
    );

    // Static status outputs
    assign host_wait_n = 1'b1;
    assign host_wp     = wp_switch;

    // Assertions
    assert_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ce_lo_n && host_ce_hi_n) |=>
            (&dev_cs_lo_n && &dev_cs_hi_n && attr_cs_n && mem_wr_n && mem_rd_n && host_d_oe == 2'b00));

    assert_lane_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_d_oe != 2'b00) |-> (!mem_rd_n && mem_wr_n));

    assert_invalid_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_oe_n && !host_we_n) |=> (mem_rd_n && mem_wr_n && host_d_oe == 2'b00));

    assert_attr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !attr_cs_n |-> (&dev_cs_lo_n && &dev_cs_hi_n));

    assert_one_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0(~dev_cs_lo_n) && $onehot0(~dev_cs_hi_n)));

    assert_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_switch && host_attr_n && !host_we_n) |=> mem_wr_n);

    assert_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_wait_n && (host_wp == wp_switch));
endmodule

// File: tb/test_sramcard_decoder.sv
module test_sramcard_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int DEV_AW = 4;
    localparam int BANK_W = 2;
    localparam int ATT_AW = 3;
    localparam int AW     = DEV_AW + BANK_W;
    localparam int NB     = 1 << BANK_W;
    localparam int DEPTH  = 1 << DEV_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_lo_n = 1'b1, ce_hi_n = 1'b1, a0 = 1'b0;
    logic [AW-1:0] addr = '0;
    logic oe_n = 1'b1, we_n = 1'b1, attr_n = 1'b1, wp = 1'b0;
    logic [15:0] d_in = '0;
    logic [15:0] d_out;
    logic [1:0]  d_oe;
    logic wait_n, wp_o;
    logic [DEV_AW-1:0] dev_addr;
    logic [NB-1:0] cs_lo_n, cs_hi_n;
    logic rd_n, wr_n;
    logic [7:0] wd_lo, wd_hi, rd_lo_m, rd_hi_m, att_rd_m;
    logic [ATT_AW-1:0] att_addr;
    logic att_cs_n;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sramcard_decoder #(.DEV_AW(DEV_AW), .BANK_W(BANK_W), .ATT_AW(ATT_AW)) i_sramcard_decoder (
        .clk(clk), .rst_n(rst_n), .host_ce_lo_n(ce_lo_n), .host_ce_hi_n(ce_hi_n),
        .host_a0(a0), .host_addr(addr), .host_oe_n(oe_n), .host_we_n(we_n),
        .host_attr_n(attr_n), .wp_switch(wp), .host_d_in(d_in), .host_d_out(d_out),
        .host_d_oe(d_oe), .host_wait_n(wait_n), .host_wp(wp_o), .dev_addr(dev_addr),
        .dev_cs_lo_n(cs_lo_n), .dev_cs_hi_n(cs_hi_n), .mem_rd_n(rd_n), .mem_wr_n(wr_n),
        .dev_wd_lo(wd_lo), .dev_wd_hi(wd_hi), .dev_rd_lo(rd_lo_m), .dev_rd_hi(rd_hi_m),
        .attr_addr(att_addr), .attr_cs_n(att_cs_n), .attr_rd(att_rd_m)
    );

    // Device models
    logic [7:0] mem_lo [NB][DEPTH];
    logic [7:0] mem_hi [NB][DEPTH];
    logic [7:0] mem_att [1 << ATT_AW];

    initial begin
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < DEPTH; i++) begin
                mem_lo[b][i] = 8'h00;
                mem_hi[b][i] = 8'h00;
            end
        for (int i = 0; i < (1 << ATT_AW); i++) mem_att[i] = 8'h00;
    end

    always_comb begin
        rd_lo_m = 8'h00;
        rd_hi_m = 8'h00;
        for (int b = 0; b < NB; b++) begin
            if (!cs_lo_n[b]) rd_lo_m = mem_lo[b][dev_addr];
            if (!cs_hi_n[b]) rd_hi_m = mem_hi[b][dev_addr];
        end
        att_rd_m = att_cs_n ? 8'h00 : mem_att[att_addr];
    end

    always @(posedge clk) begin
        if (!wr_n) begin
            for (int b = 0; b < NB; b++) begin
                if (!cs_lo_n[b]) mem_lo[b][dev_addr] <= wd_lo;
                if (!cs_hi_n[b]) mem_hi[b][dev_addr] <= wd_hi;
            end
            if (!att_cs_n) mem_att[att_addr] <= wd_lo;
        end
    end

    always @(posedge clk) cyc++;

    // Reference contents, independent of the device models
    logic [7:0] ref_c [2*NB*DEPTH];
    logic [7:0] ref_a [1 << ATT_AW];
    initial begin
        for (int i = 0; i < 2*NB*DEPTH; i++) ref_c[i] = 8'h00;
        for (int i = 0; i < (1 << ATT_AW); i++) ref_a[i] = 8'h00;
    end

    typedef struct {
        int          due;
        logic [NB-1:0] cs_lo;
        logic [NB-1:0] cs_hi;
        logic        att_cs;
        logic        rd_n;
        logic        wr_n;
        logic [1:0]  oe;
        logic [15:0] dout;
        string       req;
    } exp_t;
    exp_t sb[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: present one host cycle and queue its expected result
    task automatic access(input logic cl, input logic ch, input logic a, input logic [AW-1:0] ad,
                          input logic o, input logic w, input logic at, input logic [15:0] din,
                          input string req);
        exp_t e;
        logic rd, wrt, valid, byte_m, lo_use, hi_use;
        int bk, ev, od;
        @(negedge clk);
        ce_lo_n = cl; ce_hi_n = ch; a0 = a; addr = ad; oe_n = o; we_n = w;
        attr_n = at; d_in = din;
        bk = int'(ad[AW-1:DEV_AW]);
        ev = int'({ad, 1'b0});
        od = int'({ad, 1'b1});
        rd = !o && w;
        wrt = o && !w;
        valid = (rd || wrt) && !(cl && ch);
        byte_m = !cl && ch;
        lo_use = (!cl && !ch) || (byte_m && !a);
        hi_use = (!cl && !ch) || (byte_m && a) || (cl && !ch);
        e.due = cyc + 1;
        e.cs_lo = '1; e.cs_hi = '1;
        if (valid && at) begin
            if (lo_use) e.cs_lo[bk] = 1'b0;
            if (hi_use) e.cs_hi[bk] = 1'b0;
        end
        e.att_cs = !(valid && !at && lo_use);
        e.rd_n = !(valid && rd);
        e.wr_n = !(valid && wrt && !(at && wp));
        e.oe = (valid && rd) ? {!ch, !cl} : 2'b00;
        e.dout = 16'h0000;
        if (at) begin
            if (byte_m) e.dout[7:0] = ref_c[a ? od : ev];
            else begin
                e.dout[7:0]  = ref_c[ev];
                e.dout[15:8] = ref_c[od];
            end
        end else begin
            e.dout[7:0] = lo_use ? ref_a[ad[ATT_AW-1:0]] : 8'h00;
        end
        e.req = req;
        if (valid && wrt) begin
            if (at && !wp) begin
                if (lo_use) ref_c[ev] = din[7:0];
                if (hi_use) ref_c[od] = byte_m ? din[7:0] : din[15:8];
            end else if (!at && lo_use) begin
                ref_a[ad[ATT_AW-1:0]] = din[7:0];
            end
        end
        sb.push_back(e);
    endtask

    task automatic idle(input string req);
        access(1'b1, 1'b1, 1'b0, '0, 1'b1, 1'b1, 1'b1, 16'h0, req);
    endtask

    // Monitor: compare due expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            logic [15:0] m;
            e = sb.pop_front();
            m = {{8{e.oe[1]}}, {8{e.oe[0]}}};
            check(cs_lo_n == e.cs_lo && cs_hi_n == e.cs_hi && att_cs_n == e.att_cs,
                  e.req, "selects", {cs_lo_n, cs_hi_n, 3'b0, att_cs_n},
                  {e.cs_lo, e.cs_hi, 3'b0, e.att_cs});
            check(rd_n == e.rd_n && wr_n == e.wr_n && d_oe == e.oe, e.req, "strobes/lanes",
                  {rd_n, wr_n, d_oe}, {e.rd_n, e.wr_n, e.oe});
            check((d_out & m) == (e.dout & m), e.req, "read data", d_out & m, e.dout & m);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(&cs_lo_n && &cs_hi_n && att_cs_n && rd_n && wr_n && d_oe == 2'b00,
              "R11", "reset outputs", {cs_lo_n, cs_hi_n, att_cs_n, rd_n, wr_n, d_oe},
              {{2*NB{1'b1}}, 3'b111, 2'b00});
        rst_n = 1'b1;
        // R3 / R8: word writes across banks, then word reads
        access(0, 0, 0, 6'h03, 1, 0, 1, 16'hB1A1, "R3");
        access(0, 0, 1, 6'h13, 1, 0, 1, 16'hB2A2, "R8");
        access(0, 0, 0, 6'h3F, 1, 0, 1, 16'hB4A4, "R8");
        access(0, 0, 1, 6'h03, 0, 1, 1, 16'h0, "R3");
        access(0, 0, 0, 6'h13, 0, 1, 1, 16'h0, "R8");
        access(0, 0, 0, 6'h3F, 0, 1, 1, 16'h0, "R8");
        // R2: byte writes on the low lane, even and odd
        access(0, 1, 0, 6'h25, 1, 0, 1, 16'hFF11, "R2");
        access(0, 1, 1, 6'h25, 1, 0, 1, 16'hEE22, "R2");
        access(0, 1, 0, 6'h25, 0, 1, 1, 16'h0, "R2");
        access(0, 1, 1, 6'h25, 0, 1, 1, 16'h0, "R2");
        access(0, 0, 0, 6'h25, 0, 1, 1, 16'h0, "R2");
        // R4: odd-only write and read
        access(1, 0, 0, 6'h0A, 1, 0, 1, 16'h5C00, "R4");
        access(1, 0, 1, 6'h0A, 0, 1, 1, 16'h0, "R4");
        access(0, 0, 0, 6'h0A, 0, 1, 1, 16'h0, "R4");
        // R1: standby with strobes active
        access(1, 1, 0, 6'h03, 0, 1, 1, 16'h0, "R1");
        access(1, 1, 0, 6'h03, 1, 0, 1, 16'hDEAD, "R1");
        access(0, 0, 0, 6'h03, 0, 1, 1, 16'h0, "R1");
        // R5: neither strobe active
        access(0, 0, 0, 6'h03, 1, 1, 1, 16'h1234, "R5");
        // R6: invalid cycle then readback
        access(0, 0, 0, 6'h13, 0, 0, 1, 16'h7777, "R6");
        access(0, 0, 0, 6'h13, 0, 1, 1, 16'h0, "R6");
        // R7: attribute space
        access(0, 0, 0, 6'h05, 1, 0, 0, 16'h99C3, "R7");
        access(0, 1, 1, 6'h06, 1, 0, 0, 16'h00AA, "R7");
        access(1, 0, 0, 6'h06, 1, 0, 0, 16'hBB00, "R7");
        access(0, 1, 0, 6'h05, 0, 1, 0, 16'h0, "R7");
        access(0, 1, 1, 6'h06, 0, 1, 0, 16'h0, "R7");
        access(0, 0, 0, 6'h05, 0, 1, 0, 16'h0, "R7");
        access(0, 1, 0, 6'h06, 0, 1, 0, 16'h0, "R7");
        access(0, 0, 0, 6'h05, 0, 1, 1, 16'h0, "R7");
        // R9 / R10: write protect
        @(negedge clk);
        wp = 1'b1;
        #1;
        check(wp_o == 1'b1 && wait_n == 1'b1, "R10", "wp/wait high", {wp_o, wait_n}, 2'b11);
        access(0, 0, 0, 6'h03, 1, 0, 1, 16'h4444, "R9");
        access(0, 0, 0, 6'h03, 0, 1, 1, 16'h0, "R9");
        access(0, 1, 0, 6'h07, 1, 0, 0, 16'h0066, "R9");
        access(0, 1, 0, 6'h07, 0, 1, 0, 16'h0, "R9");
        @(negedge clk);
        wp = 1'b0;
        #1;
        check(wp_o == 1'b0 && wait_n == 1'b1, "R10", "wp low wait high", {wp_o, wait_n}, 2'b01);
        access(0, 0, 0, 6'h03, 1, 0, 1, 16'h4545, "R9");
        access(0, 0, 0, 6'h03, 0, 1, 1, 16'h0, "R9");
        idle("R1");
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R11", "queue drained", sb.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule